// File: doc/BRIEF.md
# Prescaled-Enable Loadable Binary Counter

This block is a synchronous up-counter whose bits are toggle elements. Each bit has a parallel-load path. The carry that tells a bit when to toggle comes from two sources. The least-significant bit drives every higher bit directly, as a fast enable. A ripple of two-input AND gates over bits 1 and up forms each bit's toggle term, and that term sits in a register that is refreshed on every edge. While counting, the LSB is low on every other edge, and on those edges the higher bits cannot change. The ripple therefore has a full clock period to settle before any bit uses it.

The price is a rule on loads. After a load, the registered toggle terms still describe the old value. Count enable must stay low on the cycle that follows a load, so that the terms can be rebuilt from the loaded value. The block watches for breaks of this rule and raises a one-cycle violation flag. Carry-in qualifies counting, and carry-out marks the terminal count so that counters can be chained. The asynchronous reset takes effect at once, but its release is synchronised to the clock.

Top module: `prc_counter`

## Requirements
- R1: While `rst_n` is low, `q` is zero and `cout` and `holdoff_err` are low, and this happens without waiting for a clock edge.
- R2: On an edge where `ld` is high, `q` takes the value of `d`, whatever the values of `cen` and `cin`.
- R3: On an edge where `ld` is low and `cen` is low, `q` does not change.
- R4: On an edge where `ld` is low and `cen` and `cin` are both high, `q` becomes its previous value plus one, modulo 2^16, provided the hold-off rule (R7) was obeyed.
- R5: When `cin` is low, `q` does not change even if `cen` is high.
- R6: `cout` is high exactly when `q` is 0xFFFF, `cin` and `cen` are high and `ld` is low. It is combinational, with no register delay.
- R7: If an edge samples `ld` high and the next edge samples `cen` high with `ld` low, then `holdoff_err` is high for the one cycle after that second edge. Otherwise it is low.
- R8: After a one-cycle load followed by one cycle with `cen` low, counting continues correctly from the loaded value. This includes a carry through all upper bits, for example 0x7FFF to 0x8000.
- R9: Counting from 0xFFFF, with the hold-off rule obeyed, gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ld | input | 1 | Synchronous parallel load, active high, has priority over counting |
| d | input | 16 | Parallel load value |
| cen | input | 1 | Count enable |
| cin | input | 1 | Carry-in, qualifies counting |
| q | output | 16 | Count value |
| cout | output | 1 | Terminal-count carry-out |
| holdoff_err | output | 1 | Load hold-off violation flag, one cycle |

## Verification
Load and count can be requested in the same cycle. The bench provokes this by driving `ld` and `cen` high together, both in directed steps and at random. It judges the result by checking that `q` equals `d` on the next cycle and that `cout` stays low during that cycle. A load can also fall on the cycle just before counting resumes. The bench provokes this by raising `cen` right after a load. It judges the result by checking that `holdoff_err` appears one cycle later and that a fresh load, followed by its hold-off cycle, brings the count back to the value the model expects.

// File: rtl/prc_pkg.sv
package prc_pkg;

  localparam int PRC_DEFAULT_W = 16;

  // Per-bit control bundle driven by the top into each toggle cell
  typedef struct packed {
    logic load;  // parallel load request
    logic step;  // counting qualified by enable, carry-in and no load
    logic fast;  // prescaled enable: LSB state for upper bits, 1 for bit 0
  } prc_ctl_t;

endpackage

// File: rtl/prc_rst_sync.sv
module prc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/prc_toggle_cell.sv
module prc_toggle_cell
  import prc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  prc_ctl_t ctl,
  input  logic     tgl,
  input  logic     d,
  output logic     q
);

  logic q_r;
  logic q_n;
  logic flip;

  always_comb begin
    flip = ctl.step & ctl.fast & tgl;
    if (ctl.load) begin
      q_n = d;
    end else if (flip) begin
      q_n = ~q_r;
    end else begin
      q_n = q_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= 1'b0;
    end else begin
      q_r <= q_n;
    end
  end

  assign q = q_r;

  // R2: a load edge captures the data input
  p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.load |=> (q == $past(d)));

  // R3: no load and no step leaves the bit unchanged
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.load && !ctl.step) |=> $stable(q));

endmodule

// File: rtl/prc_carry_chain.sv
module prc_carry_chain #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] q,
  output logic [W-1:0] tgl
);

  // Ripple of two-input ANDs over bits 1 and up, one gate per stage
  logic [W-1:0] ripple;
  logic [W-1:2] term_q;

  assign ripple[0] = 1'b1;
  assign ripple[1] = 1'b1;

  generate
    for (genvar i = 2; i < W; i++) begin : g_stage
      if (i == 2) begin : g_first
        assign ripple[i] = q[1];
      end else begin : g_next
        assign ripple[i] = ripple[i-1] & q[i-1];
      end
    end
  endgenerate

  // Registered toggle terms, refreshed on every edge; the chain gets a full period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_q <= '0;
    end else begin
      term_q <= ripple[W-1:2];
    end
  end

  assign tgl = {term_q, 2'b11};

endmodule

// File: rtl/prc_holdoff_mon.sv
module prc_holdoff_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic ld,
  input  logic cen,
  output logic holdoff_err
);

  logic ld_q;
  logic err_q;
  logic err_n;

  always_comb begin
    err_n = ld_q & cen & ~ld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ld_q  <= ld;
      err_q <= err_n;
    end
  end

  assign holdoff_err = err_q;

  // R7: the flag is only raised after an edge that sampled enable high without load
  p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    holdoff_err |-> $past(cen && !ld));

endmodule

// File: rtl/prc_counter.sv
module prc_counter
  import prc_pkg::*;
#(
  parameter int W           = PRC_DEFAULT_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  input  logic         cen,
  input  logic         cin,
  output logic [W-1:0] q,
  output logic         cout,
  output logic         holdoff_err
);

  logic         rst_s_n;
  logic         step;
  logic [W-1:0] q_w;
  logic [W-1:0] tgl_w;
  prc_ctl_t     ctl [W];

  prc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  assign step = cen & cin & ~ld;

  prc_carry_chain #(.W(W)) u_chain (
    .clk   (clk),
    .rst_n (rst_s_n),
    .q     (q_w),
    .tgl   (tgl_w)
  );

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_lsb
        assign ctl[i] = '{load: ld, step: step, fast: 1'b1};
      end else begin : g_upper
        assign ctl[i] = '{load: ld, step: step, fast: q_w[0]};
      end
      prc_toggle_cell u_cell (
        .clk   (clk),
        .rst_n (rst_s_n),
        .ctl   (ctl[i]),
        .tgl   (tgl_w[i]),
        .d     (d[i]),
        .q     (q_w[i])
      );
    end
  endgenerate

  prc_holdoff_mon u_mon (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .ld          (ld),
    .cen         (cen),
    .holdoff_err (holdoff_err)
  );

  assign q    = q_w;
  assign cout = (&q_w) & cin & cen & ~ld;

  // R1: reset holds the count at zero
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (q == '0));

  // R4: a qualified step adds one unless the hold-off rule was broken
  p_step_incr_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cen && cin && !ld) |=> ((q == $past(q) + 1'b1) || holdoff_err));

  // R9: terminal count rolls over to zero
  p_wrap_zero_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    cout |=> ((q == '0) || holdoff_err));

endmodule

// File: tb/prc_counter_test.sv
`timescale 1ns/1ps
module prc_counter_test;

  localparam int W = 16;
  localparam logic [W-1:0] ALL1 = '1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ld;
  logic [W-1:0] d;
  logic         cen;
  logic         cin;
  logic [W-1:0] q;
  logic         cout;
  logic         holdoff_err;

  int n_chk  = 0;
  int n_fail = 0;

  logic [W-1:0] m_q;
  logic         m_flag;
  logic         m_prev_ld;
  logic         m_valid;

  always #2.5 clk = ~clk;

  prc_counter #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .ld(ld), .d(d), .cen(cen), .cin(cin),
    .q(q), .cout(cout), .holdoff_err(holdoff_err)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] next_count(input logic [W-1:0] cur, input logic l,
                                               input logic [W-1:0] dv, input logic c,
                                               input logic ci);
    if (l) return dv;
    if (c && ci) return cur + 1'b1;
    return cur;
  endfunction

  function automatic logic exp_cout(input logic [W-1:0] cur, input logic l,
                                    input logic c, input logic ci);
    return (cur == ALL1) && c && ci && !l;
  endfunction

  task automatic model_reset();
    m_q = '0; m_flag = 1'b0; m_prev_ld = 1'b0; m_valid = 1'b1;
  endtask

  // One cycle: check outputs from the last edge, drive, check cout, take the edge
  task automatic cyc(input logic l, input logic [W-1:0] dv, input logic c,
                     input logic ci, input string tag);
    logic viol;
    @(negedge clk);
    if (m_valid) check(q == m_q, tag, q, m_q);
    check(holdoff_err == m_flag, "R7", W'(holdoff_err), W'(m_flag));
    ld = l; d = dv; cen = c; cin = ci;
    #1;
    if (m_valid)
      check(cout == exp_cout(m_q, l, c, ci), "R6", W'(cout), W'(exp_cout(m_q, l, c, ci)));
    @(posedge clk);
    viol      = m_prev_ld && c && !l;
    m_flag    = viol;
    m_prev_ld = l;
    if (l) m_valid = 1'b1;
    else if (viol) m_valid = 1'b0;
    m_q = next_count(m_q, l, dv, c, ci);
  endtask

  task automatic load_then_hold(input logic [W-1:0] v, input logic c_on_load,
                                input string tag);
    cyc(1'b1, v, c_on_load, 1'b1, tag);
    cyc(1'b0, '0, 1'b0, 1'b1, tag);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    ld = 0; d = '0; cen = 0; cin = 0;
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check(q == '0, "R1", q, '0);
    check(cout == 1'b0 && holdoff_err == 1'b0, "R1", W'({cout, holdoff_err}), '0);
    rst_n = 1'b1;
    repeat (4) cyc(1'b0, '0, 1'b0, 1'b1, "R1");

    // counting from zero
    repeat (5) cyc(1'b0, '0, 1'b1, 1'b1, "R4");

    // load wins over enable
    load_then_hold(16'h1234, 1'b1, "R2");
    repeat (3) cyc(1'b0, 16'hFFFF, 1'b0, 1'b1, "R3");
    repeat (3) cyc(1'b0, 16'hFFFF, 1'b1, 1'b0, "R5");

    // full-length carry after load
    load_then_hold(16'h7FFE, 1'b0, "R8");
    repeat (3) cyc(1'b0, '0, 1'b1, 1'b1, "R8");

    // terminal count and rollover
    load_then_hold(16'hFFFE, 1'b0, "R9");
    repeat (3) cyc(1'b0, '0, 1'b1, 1'b1, "R9");
    load_then_hold(16'hFFFF, 1'b0, "R6");
    cyc(1'b1, 16'h00AA, 1'b1, 1'b1, "R6");
    cyc(1'b0, '0, 1'b0, 1'b0, "R6");

    // hold-off violation, then recovery by a fresh load
    cyc(1'b1, 16'h0FFF, 1'b0, 1'b1, "R7");
    cyc(1'b0, '0, 1'b1, 1'b1, "R7");
    cyc(1'b0, '0, 1'b0, 1'b1, "R7");
    load_then_hold(16'h00FF, 1'b0, "R8");
    repeat (3) cyc(1'b0, '0, 1'b1, 1'b1, "R8");

    // asynchronous reset in mid-cycle
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check(q == '0, "R1", q, '0);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cyc(1'b0, '0, 1'b0, 1'b1, "R1");

    // constrained random, hold-off obeyed
    for (int k = 0; k < 4000; k++) begin
      logic         l;
      logic         c;
      logic         ci;
      logic [W-1:0] dv;
      l  = ($urandom_range(0, 15) == 0);
      ci = ($urandom_range(0, 7) != 0);
      c  = m_prev_ld ? l & $urandom_range(0, 1) : ($urandom_range(0, 7) != 0);
      case ($urandom_range(0, 3))
        0: dv = 16'hFFFF - W'($urandom_range(0, 3));
        1: dv = 16'h7FFF - W'($urandom_range(0, 3));
        2: dv = 16'h00FF - W'($urandom_range(0, 3));
        default: dv = W'($urandom);
      endcase
      cyc(l, dv, c, ci, "R4");
    end
    cyc(1'b0, '0, 1'b0, 1'b1, "R4");

    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end

endmodule